// File: doc/BRIEF.md
# Sign-Magnitude Radix-4 Booth Partial-Product Generator

This block forms the partial products of a signed integer multiplication in the radix-4 Booth style. The multiplicand arrives in two's complement and is turned into sign-magnitude form. A positive value passes through unchanged. A negative value has every bit below the sign inverted, and the increment that would finish the negation is left out. Because the operand is held as sign and magnitude, each negated selection only changes one sign flag and leaves the magnitude bits alone. The multiplier stays in two's complement. It is cut into overlapping three-bit groups, with a zero placed below the least significant bit. Every group is decoded at once, and each group picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand.

Each partial product leaves the block as a row of redundant-binary digits. A digit is a (negative flag, magnitude bit) pair, produced by wiring the row sign to every magnitude bit. The increment that the conversion left out is not added here. Each row also gets up to one correction digit, which a downstream adder tree sums with the rows. All outputs are registered once, and the final product is not formed inside this block.

Top module: `smb_booth_ppgen`

## Requirements
- R1: While reset is held, and for the two clocks after it is released, every row digit and every correction digit reads zero.
- R2: Each output reflects the operands sampled at the previous rising clock edge, and it stays stable while the inputs change between edges.
- R3: The multiplier is scanned in (N+1)/2 groups. Group k is bits (2k+1, 2k, 2k-1), bit -1 is zero, and for odd N the multiplier's sign bit is repeated above bit N-1.
- R4: A group of 000 or 111 selects zero. Its row then has every magnitude bit and every negative flag at 0, and both of its correction digits are 0.
- R5: In a row with a non-zero selection, every digit's negative flag equals (multiplicand negative) XOR (selection negative).
- R6: The row magnitude is M, or 2M for a double selection. M is the multiplicand itself when it is non-negative, and its bitwise complement below the sign when it is negative. Digit i of row k has weight 2^(2k+i), and the rows are N digits wide.
- R7: Each row has two correction digits, at weights 2^(2k) and 2^(2k+1). Exactly one of them has magnitude 1 only when the multiplicand is negative and the selection is non-zero: the lower one for a single selection, the upper one for a double selection. Its negative flag equals the row's flag. In all other cases both correction digits are zero, and a correction digit's flag is never set without its magnitude.
- R8: Adding every signed digit and correction digit at its weight gives the exact signed product of multiplier and multiplicand, for every pair of operand values.
- R9: Groups 001 and 010 select +Y, group 011 selects +2Y, group 100 selects -2Y, and groups 101 and 110 select -Y. The value of row k plus its correction digits equals that selection times Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| pp_mag_o | output | ((N+1)/2)*N | Digit magnitudes; row k occupies bits k*N to k*N+N-1 |
| pp_neg_o | output | ((N+1)/2)*N | Digit negative flags, same layout as pp_mag_o |
| cor_mag_o | output | 2*((N+1)/2) | Correction magnitudes; bits 2k and 2k+1 belong to row k |
| cor_neg_o | output | 2*((N+1)/2) | Correction negative flags, same layout as cor_mag_o |

## Verification
Every output is due one rising edge after the operands are presented. The bench changes operands on a falling edge and reads results on the next falling edge, so exactly one register update lies between stimulus and sample. The latency check changes the operands and reads the outputs before the following rising edge, and expects the earlier results to still be held. An eight-bit instance and a five-bit instance, which exercises the odd-width sign extension, are driven through every operand pair. Rows, correction digits, per-row values and the recombined product are all compared against values the bench computes itself.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  // decoded Booth selection: magnitude class plus a negate flag
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bsel_t;
endpackage

// File: rtl/smb_sm_conv.sv
`timescale 1ns/1ps
module smb_sm_conv #(
  parameter int N = 8
) (
  input  logic [N-1:0] tc_i,
  output logic         sgn_o,
  output logic [N-2:0] mag_o
);
  // negative values: invert below the sign; the +1 travels as a correction digit
  always_comb begin
    sgn_o = tc_i[N-1];
    mag_o = tc_i[N-2:0] ^ {(N-1){tc_i[N-1]}};
  end
endmodule

// File: rtl/smb_booth_dec.sv
`timescale 1ns/1ps
module smb_booth_dec
  import smb_pkg::*;
(
  input  logic [2:0] trip_i,
  output bsel_t      sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (trip_i)
      3'b001, 3'b010: sel_o.one = 1'b1;
      3'b011:         sel_o.two = 1'b1;
      3'b100:         begin sel_o.two = 1'b1; sel_o.neg = 1'b1; end
      3'b101, 3'b110: begin sel_o.one = 1'b1; sel_o.neg = 1'b1; end
      default:        sel_o = '0;
    endcase
  end
endmodule

// File: rtl/smb_pp_row.sv
`timescale 1ns/1ps
module smb_pp_row
  import smb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         ysgn_i,
  input  logic [N-2:0] ymag_i,
  input  bsel_t        sel_i,
  output logic [N-1:0] dmag_o,
  output logic [N-1:0] dneg_o,
  output logic [1:0]   cmag_o,
  output logic [1:0]   cneg_o
);
  logic active;
  logic row_sgn;

  always_comb begin
    active  = sel_i.one | sel_i.two;
    row_sgn = active & (ysgn_i ^ sel_i.neg);
  end

  // digit placement: single selection at offset 0, double at offset 1
  for (genvar i = 0; i < N; i++) begin : g_dig
    if (i == 0) begin : g_lo
      assign dmag_o[i] = sel_i.one & ymag_i[i];
    end else if (i == N-1) begin : g_hi
      assign dmag_o[i] = sel_i.two & ymag_i[i-1];
    end else begin : g_mid
      assign dmag_o[i] = (sel_i.one & ymag_i[i]) | (sel_i.two & ymag_i[i-1]);
    end
    assign dneg_o[i] = row_sgn;
  end

  always_comb begin
    cmag_o = {ysgn_i & sel_i.two, ysgn_i & sel_i.one};
    cneg_o = cmag_o & {2{row_sgn}};
  end
endmodule

// File: rtl/smb_booth_ppgen.sv
`timescale 1ns/1ps
module smb_booth_ppgen
  import smb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              mcand_i,
  input  logic [N-1:0]              mplier_i,
  output logic [((N+1)/2)*N-1:0]    pp_mag_o,
  output logic [((N+1)/2)*N-1:0]    pp_neg_o,
  output logic [2*((N+1)/2)-1:0]    cor_mag_o,
  output logic [2*((N+1)/2)-1:0]    cor_neg_o
);
  localparam int NPP = (N + 1) / 2;
  localparam int XW  = 2 * NPP + 1;
  localparam int PW  = NPP * N;
  localparam int CW  = 2 * NPP;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // multiplicand to sign-magnitude
  logic         ysgn;
  logic [N-2:0] ymag;
  smb_sm_conv #(.N(N)) u_conv (
    .tc_i  (mcand_i),
    .sgn_o (ysgn),
    .mag_o (ymag)
  );

  // extended multiplier: zero below, sign copy above when N is odd
  logic [XW-1:0] xe;
  always_comb begin
    xe = '0;
    xe[N:1] = mplier_i;
    for (int i = N + 1; i < XW; i++) xe[i] = mplier_i[N-1];
  end

  logic [PW-1:0] pp_mag_nx, pp_neg_nx;
  logic [CW-1:0] cor_mag_nx, cor_neg_nx;

  for (genvar k = 0; k < NPP; k++) begin : g_row
    bsel_t sel;
    smb_booth_dec u_dec (
      .trip_i (xe[2*k+2:2*k]),
      .sel_o  (sel)
    );
    smb_pp_row #(.N(N)) u_row (
      .ysgn_i (ysgn),
      .ymag_i (ymag),
      .sel_i  (sel),
      .dmag_o (pp_mag_nx[k*N +: N]),
      .dneg_o (pp_neg_nx[k*N +: N]),
      .cmag_o (cor_mag_nx[2*k +: 2]),
      .cneg_o (cor_neg_nx[2*k +: 2])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pp_mag_o  <= '0;
      pp_neg_o  <= '0;
      cor_mag_o <= '0;
      cor_neg_o <= '0;
    end else begin
      pp_mag_o  <= pp_mag_nx;
      pp_neg_o  <= pp_neg_nx;
      cor_mag_o <= cor_mag_nx;
      cor_neg_o <= cor_neg_nx;
    end
  end

  // per-row checks on the registered outputs
  for (genvar k = 0; k < NPP; k++) begin : g_chk
    assert_zero_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(xe[2*k+2:2*k]) == 3'b000) || ($past(xe[2*k+2:2*k]) == 3'b111))
      |-> (pp_mag_o[k*N +: N] == '0 && pp_neg_o[k*N +: N] == '0 &&
           cor_mag_o[2*k +: 2] == 2'b00));
    assert_uniform_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|pp_neg_o[k*N +: N]) |-> (&pp_neg_o[k*N +: N]));
    assert_pos_no_corr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mcand_i[N-1]) |-> (cor_mag_o[2*k +: 2] == 2'b00));
    assert_single_corr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cor_mag_o[2*k +: 2]) && ((cor_neg_o[2*k +: 2] & ~cor_mag_o[2*k +: 2]) == 2'b00));
  end
endmodule

// File: tb/smb_booth_ppgen_test.sv
`timescale 1ns/1ps
module smb_booth_ppgen_test;
  logic clk;
  logic rst_n;
  logic [7:0]  mc8, mp8;
  logic [31:0] pm8, pn8;
  logic [7:0]  cm8, cn8;
  logic [4:0]  mc5, mp5;
  logic [14:0] pm5, pn5;
  logic [5:0]  cm5, cn5;
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  smb_booth_ppgen #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .mcand_i(mc8), .mplier_i(mp8),
    .pp_mag_o(pm8), .pp_neg_o(pn8), .cor_mag_o(cm8), .cor_neg_o(cn8));

  smb_booth_ppgen #(.N(5)) uut_odd (
    .clk(clk), .rst_n(rst_n), .mcand_i(mc5), .mplier_i(mp5),
    .pp_mag_o(pm5), .pp_neg_o(pn5), .cor_mag_o(cm5), .cor_neg_o(cn5));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int xbit(input int x, input int n, input int i);
    if (i < 0) return 0;
    if (i >= n) return (x >> (n - 1)) & 1;
    return (x >> i) & 1;
  endfunction

  task automatic check_inst(input int n, input int xr, input int yr,
                            input logic [63:0] pm, input logic [63:0] pn,
                            input logic [15:0] cm, input logic [15:0] cn);
    int sx, sy, npp, sel, am, ymag, t;
    bit flag;
    longint total, rowv, expm, gotm, gotn, expn, gc, gcn, expc, expcn;
    sx = (xr >= (1 << (n - 1))) ? xr - (1 << n) : xr;
    sy = (yr >= (1 << (n - 1))) ? yr - (1 << n) : yr;
    npp = (n + 1) / 2;
    ymag = (sy < 0) ? -sy - 1 : sy;
    total = 0;
    for (int k = 0; k < npp; k++) begin
      t = xbit(xr, n, 2*k+1) * 4 + xbit(xr, n, 2*k) * 2 + xbit(xr, n, 2*k-1);
      case (t)
        1, 2:    sel = 1;
        3:       sel = 2;
        4:       sel = -2;
        5, 6:    sel = -1;
        default: sel = 0;
      endcase
      am = (sel < 0) ? -sel : sel;
      flag = (sel != 0) && ((sy < 0) != (sel < 0));
      expm = (am == 0) ? 0 : ((am == 1) ? ymag : 2 * ymag);
      expn = flag ? ((64'sd1 <<< n) - 1) : 0;
      gotm = 0; gotn = 0; rowv = 0;
      for (int i = 0; i < n; i++) begin
        gotm |= longint'(pm[k*n+i]) << i;
        gotn |= longint'(pn[k*n+i]) << i;
        if (pm[k*n+i]) rowv += (pn[k*n+i] ? -1 : 1) * (64'sd1 <<< i);
      end
      // R4 zero rows, R6 magnitude placement
      chk(gotm == expm, (sel == 0) ? "R4" : "R6", $sformatf("n=%0d x=%0d y=%0d row %0d magnitude", n, sx, sy, k), gotm, expm);
      // R4 zero rows, R5 row sign
      chk(gotn == expn, (sel == 0) ? "R4" : "R5", $sformatf("n=%0d x=%0d y=%0d row %0d flags", n, sx, sy, k), gotn, expn);
      expc  = ((sy < 0) && (sel != 0)) ? ((am == 2) ? 2 : 1) : 0;
      expcn = flag ? expc : 0;
      gc  = {cm[2*k+1], cm[2*k]};
      gcn = {cn[2*k+1], cn[2*k]};
      // R7 correction digits
      chk(gc == expc && gcn == expcn, "R7", $sformatf("n=%0d x=%0d y=%0d row %0d correction mag*4+flags", n, sx, sy, k),
          gc * 4 + gcn, expc * 4 + expcn);
      if (cm[2*k])   rowv += cn[2*k]   ? -1 : 1;
      if (cm[2*k+1]) rowv += cn[2*k+1] ? -2 : 2;
      // R9 selection table
      chk(rowv == longint'(sel) * sy, "R9", $sformatf("n=%0d x=%0d y=%0d row %0d value", n, sx, sy, k), rowv, longint'(sel) * sy);
      total += rowv <<< (2 * k);
    end
    // R3 scanning plus R8 full product
    chk(total == longint'(sx) * sy, "R3 R8", $sformatf("n=%0d x=%0d y=%0d product", n, sx, sy), total, longint'(sx) * sy);
  endtask

  task automatic check_zero(input string req);
    chk(pm8 == '0 && pn8 == '0 && cm8 == '0 && cn8 == '0, req, "n=8 outputs clear",
        longint'(pm8) | longint'(pn8) | longint'(cm8) | longint'(cn8), 0);
    chk(pm5 == '0 && pn5 == '0 && cm5 == '0 && cn5 == '0, req, "n=5 outputs clear",
        longint'(pm5) | longint'(pn5) | longint'(cm5) | longint'(cn5), 0);
  endtask

  task automatic drive(input int x, input int y);
    mp8 = x[7:0]; mc8 = y[7:0];
    mp5 = x[4:0]; mc5 = y[4:0];
  endtask

  task automatic check_both(input int x, input int y);
    check_inst(8, x & 255, y & 255, 64'(pm8), 64'(pn8), 16'(cm8), 16'(cn8));
    check_inst(5, x & 31, y & 31, 64'(pm5), 64'(pn5), 16'(cm5), 16'(cn5));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    logic [31:0] held_pm;
    logic [7:0]  held_cm;
    rst_n = 1'b0;
    drive(8'hA5, 8'h9C);
    repeat (3) @(negedge clk);
    check_zero("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_zero("R1");
    repeat (2) @(negedge clk);
    // R2: one-edge latency, held between edges
    drive(8'h5A, 8'hFD);
    @(negedge clk);
    check_both(8'h5A, 8'hFD);
    held_pm = pm8; held_cm = cm8;
    drive(8'h33, 8'h07);
    #1;
    chk(pm8 == held_pm && cm8 == held_cm, "R2", "outputs held before edge",
        longint'(pm8), longint'(held_pm));
    @(negedge clk);
    check_both(8'h33, 8'h07);
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        drive(x, y);
        @(negedge clk);
        check_both(x, y);
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule